// File: doc/BRIEF.md
# Fully Associative Address Translation Cache with True LRU Replacement

This block holds a small set of recent page translations. Each cycle a lookup presents a virtual page number, a page offset, a process tag and the kind of access wanted. Every stored entry is compared with that key at once. The answer is combinational. It is one of three outcomes:

- a permitted hit, which carries a physical address;
- a protection fault, where the entry exists but denies the access;
- a miss, which tells an outside page walker to fetch the translation.

The walker later delivers the translation on the fill port. The block then writes it into a free slot, or into the least recently used slot if none is free.

Software can drop one translation by giving its page and tag. It can also empty the whole cache in one cycle, for example on a context switch. Two saturating counters record permitted hits and misses, so the hit ratio can be read.

The block keeps a full recency ranking of all entries, not an approximation. All state changes happen on the rising clock edge.

Top module: `xlat_cache`

## Requirements
- R1: An entry matches a lookup only when it is valid and both its stored page number and its process tag equal the lookup's. A differing tag alone gives a miss.
- R2: On a permitted hit, `lk_paddr` is the entry's frame number in the upper bits, joined with the unchanged `lk_off` in the low `OFF_W` bits. In every other case `lk_paddr` is zero.
- R3: Access and permission bits share one encoding: bit 0 is read, bit 1 is write, bit 2 is execute. A match whose request sets any bit that the entry does not grant raises `lk_fault` and not `lk_hit`. With no match, `lk_miss` is raised. At most one of the three outputs is high, and none is high when `lk_valid` is low.
- R4: The entries hold a strict recency ranking. When a matching lookup updates recency, that entry becomes most recent, and each entry that was more recent than it moves back one place. A matching lookup that faults also updates recency.
- R5: An accepted fill goes into the lowest-numbered invalid entry. If every entry is valid, it goes into the least recently used entry. The filled entry becomes most recent and is found by the next cycle's lookup.
- R6: `flush_en` clears every valid bit at the next clock edge.
- R7: `inv_en` clears only the entry whose page number and tag both equal `inv_vpn` and `inv_tag`. If the tag differs, nothing changes.
- R8: A fill is dropped when `flush_en` or `inv_en` is high in the same cycle. A lookup updates recency only in a cycle with no fill, invalidate or flush request.
- R9: `hit_count` counts permitted hits and `miss_count` counts misses. Each counts only while `lk_valid` is high, and each stops at its all-ones value.
- R10: After reset no entry is valid and both counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_off | input | OFF_W | Lookup page offset |
| lk_tag | input | TAG_W | Current process tag |
| lk_acc | input | 3 | Requested access: bit 0 read, bit 1 write, bit 2 execute |
| lk_hit | output | 1 | Permitted translation found |
| lk_miss | output | 1 | No matching entry |
| lk_fault | output | 1 | Matching entry denies the access |
| lk_paddr | output | PFN_W+OFF_W | Physical address on a permitted hit, otherwise zero |
| fill_en | input | 1 | Install a translation from the walker |
| fill_vpn | input | VPN_W | Page number to install |
| fill_tag | input | TAG_W | Process tag to install |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_perm | input | 3 | Permissions to install, same encoding as `lk_acc` |
| inv_en | input | 1 | Invalidate one translation |
| inv_vpn | input | VPN_W | Page number to invalidate |
| inv_tag | input | TAG_W | Process tag to invalidate |
| flush_en | input | 1 | Invalidate every entry |
| hit_count | output | CNT_W | Saturating count of permitted hits |
| miss_count | output | CNT_W | Saturating count of misses |

## Verification
A directed phase first fills every slot in order, then touches the oldest entry, then adds a ninth key. That sequence shows whether the replacement slot follows the lowest free slot or the recency ranking. Later directed steps separate three cases:

- a tag mismatch on an equal page number;
- a read-only page hit by a write;
- a wrong-tag invalidate compared with the correct one.

Flush and invalidate are also raised together with a fill, to check which request wins.

A long random phase then uses a key space of only a few pages and tags. That makes hits, misses, faults, evictions and mixed same-cycle requests all frequent, so a fault in the recency update or in victim choice soon shows up as a wrong hit or miss. A burst of repeated hits pushes the narrowed counters past their all-ones value.

// File: rtl/xlat_pkg.sv
// Package xlat_pkg
// Shared definitions for the translation cache: the permission vector
// layout (bit 0 read, bit 1 write, bit 2 execute) and the access check.
package xlat_pkg;

    localparam int PERM_W  = 3;
    localparam int P_READ  = 0;
    localparam int P_WRITE = 1;
    localparam int P_EXEC  = 2;

    typedef logic [PERM_W-1:0] perm_t;

    // True when the request asks for any right the entry does not grant.
    function automatic logic perm_denied(perm_t want, perm_t have);
        return |(want & ~have);
    endfunction

endpackage

// File: rtl/xlat_match.sv
// Module xlat_match
// Compares one key (page number and process tag) against every entry in
// parallel and returns a per-entry match vector. Only valid entries match.
// Assumes entries never hold duplicate keys, so at most one bit is set.
module xlat_match #(
    parameter int N     = 8,
    parameter int VPN_W = 20,
    parameter int TAG_W = 8
) (
    input  logic [VPN_W-1:0]          key_vpn,
    input  logic [TAG_W-1:0]          key_tag,
    input  logic [N-1:0]              ent_valid,
    input  logic [N-1:0][VPN_W-1:0]   ent_vpn,
    input  logic [N-1:0][TAG_W-1:0]   ent_tag,
    output logic [N-1:0]              match_vec
);

    for (genvar i = 0; i < N; i++) begin : g_cmp
        // Per-entry comparator: valid, page and tag must all agree.
        always_comb begin
            match_vec[i] = ent_valid[i]
                         && (ent_vpn[i] == key_vpn)
                         && (ent_tag[i] == key_tag);
        end
    end

endmodule

// File: rtl/xlat_store.sv
// Module xlat_store
// Register file of translation entries. One write port installs a full
// entry; a kill mask clears valid bits. The kill mask and the write are
// never both active: the top gives kill requests priority.
module xlat_store #(
    parameter int N     = 8,
    parameter int VPN_W = 20,
    parameter int PFN_W = 20,
    parameter int TAG_W = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [VPN_W-1:0]          wr_vpn,
    input  logic [TAG_W-1:0]          wr_tag,
    input  logic [PFN_W-1:0]          wr_pfn,
    input  xlat_pkg::perm_t           wr_perm,
    input  logic [N-1:0]              kill_mask,
    output logic [N-1:0]              valid_q,
    output logic [N-1:0][VPN_W-1:0]   vpn_q,
    output logic [N-1:0][TAG_W-1:0]   tag_q,
    output logic [N-1:0][PFN_W-1:0]   pfn_q,
    output xlat_pkg::perm_t [N-1:0]   perm_q
);

    for (genvar i = 0; i < N; i++) begin : g_ent
        logic sel;
        // Decode whether this entry is the write target.
        always_comb sel = wr_en && (wr_idx == IDX_W'(i));

        // Valid bit: cleared by reset or kill, set by a write.
        always_ff @(posedge clk) begin
            if (!rst_n)            valid_q[i] <= 1'b0;
            else if (kill_mask[i]) valid_q[i] <= 1'b0;
            else if (sel)          valid_q[i] <= 1'b1;
        end

        // Payload fields: loaded on a write, otherwise held.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vpn_q[i]  <= '0;
                tag_q[i]  <= '0;
                pfn_q[i]  <= '0;
                perm_q[i] <= '0;
            end else if (sel) begin
                vpn_q[i]  <= wr_vpn;
                tag_q[i]  <= wr_tag;
                pfn_q[i]  <= wr_pfn;
                perm_q[i] <= wr_perm;
            end
        end
    end

endmodule

// File: rtl/xlat_recency.sv
// Module xlat_recency
// True LRU ranking: each entry holds an age, 0 = most recent and N-1 =
// least recent. The ages form a permutation from reset on. A touch sets
// the chosen entry to 0 and ages every younger entry by one.
module xlat_recency #(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    touch_en,
    input  logic [IDX_W-1:0]        touch_idx,
    output logic [N-1:0][IDX_W-1:0] age_q,
    output logic [IDX_W-1:0]        lru_idx
);

    logic [IDX_W-1:0] touch_age;

    // Age of the entry being touched, the pivot for the update.
    always_comb touch_age = age_q[touch_idx];

    for (genvar i = 0; i < N; i++) begin : g_age
        // Per-entry age update on a touch.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                age_q[i] <= IDX_W'(i);
            end else if (touch_en) begin
                if (touch_idx == IDX_W'(i))  age_q[i] <= '0;
                else if (age_q[i] < touch_age) age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    // Locate the entry holding the oldest age.
    always_comb begin
        lru_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (age_q[i] == IDX_W'(N - 1)) lru_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/xlat_sat_ctr.sv
// Module xlat_sat_ctr
// Event counter that increments on inc and stops at its all-ones value.
module xlat_sat_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);

    // Count up until saturated.
    always_ff @(posedge clk) begin
        if (!rst_n)                   count <= '0;
        else if (inc && (count != '1)) count <= count + 1'b1;
    end

endmodule

// File: rtl/xlat_cache.sv
// Module xlat_cache
// Fully associative translation cache with true LRU replacement,
// per-entry process tags and read/write/execute checks. The lookup
// result is combinational; fills, invalidates, flushes, recency and
// counters update on the rising edge. Assumes the walker never fills a
// key that is already present.
module xlat_cache #(
    parameter int N     = 8,
    parameter int VPN_W = 20,
    parameter int PFN_W = 20,
    parameter int TAG_W = 8,
    parameter int OFF_W = 12,
    parameter int CNT_W = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
    localparam int PA_W  = PFN_W + OFF_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lk_valid,
    input  logic [VPN_W-1:0]      lk_vpn,
    input  logic [OFF_W-1:0]      lk_off,
    input  logic [TAG_W-1:0]      lk_tag,
    input  logic [2:0]            lk_acc,
    output logic                  lk_hit,
    output logic                  lk_miss,
    output logic                  lk_fault,
    output logic [PA_W-1:0]       lk_paddr,
    input  logic                  fill_en,
    input  logic [VPN_W-1:0]      fill_vpn,
    input  logic [TAG_W-1:0]      fill_tag,
    input  logic [PFN_W-1:0]      fill_pfn,
    input  logic [2:0]            fill_perm,
    input  logic                  inv_en,
    input  logic [VPN_W-1:0]      inv_vpn,
    input  logic [TAG_W-1:0]      inv_tag,
    input  logic                  flush_en,
    output logic [CNT_W-1:0]      hit_count,
    output logic [CNT_W-1:0]      miss_count
);

    import xlat_pkg::*;

    logic [N-1:0]              valid_q;
    logic [N-1:0][VPN_W-1:0]   vpn_q;
    logic [N-1:0][TAG_W-1:0]   tag_q;
    logic [N-1:0][PFN_W-1:0]   pfn_q;
    perm_t [N-1:0]             perm_q;
    logic [N-1:0][IDX_W-1:0]   age_q;
    logic [N-1:0]              lk_match;
    logic [N-1:0]              inv_match;
    logic [N-1:0]              kill_mask;
    logic [IDX_W-1:0]          hit_idx;
    logic [IDX_W-1:0]          lru_idx;
    logic [IDX_W-1:0]          free_idx;
    logic [IDX_W-1:0]          victim_idx;
    logic                      have_free;
    logic                      any_match;
    logic                      denied;
    logic                      fill_go;
    logic                      touch_en;
    logic [IDX_W-1:0]          touch_idx;

    xlat_store #(.N(N), .VPN_W(VPN_W), .PFN_W(PFN_W), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(fill_go), .wr_idx(victim_idx),
        .wr_vpn(fill_vpn), .wr_tag(fill_tag), .wr_pfn(fill_pfn), .wr_perm(fill_perm),
        .kill_mask(kill_mask),
        .valid_q(valid_q), .vpn_q(vpn_q), .tag_q(tag_q), .pfn_q(pfn_q), .perm_q(perm_q)
    );

    xlat_match #(.N(N), .VPN_W(VPN_W), .TAG_W(TAG_W)) u_lk_cmp (
        .key_vpn(lk_vpn), .key_tag(lk_tag),
        .ent_valid(valid_q), .ent_vpn(vpn_q), .ent_tag(tag_q),
        .match_vec(lk_match)
    );

    xlat_match #(.N(N), .VPN_W(VPN_W), .TAG_W(TAG_W)) u_inv_cmp (
        .key_vpn(inv_vpn), .key_tag(inv_tag),
        .ent_valid(valid_q), .ent_vpn(vpn_q), .ent_tag(tag_q),
        .match_vec(inv_match)
    );

    xlat_recency #(.N(N)) u_rank (
        .clk(clk), .rst_n(rst_n),
        .touch_en(touch_en), .touch_idx(touch_idx),
        .age_q(age_q), .lru_idx(lru_idx)
    );

    // Encode the one-hot lookup match into an index.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (lk_match[i]) hit_idx = IDX_W'(i);
        end
    end

    // Lookup outcome: permission check and the three exclusive results.
    always_comb begin
        any_match = |lk_match;
        denied    = perm_denied(lk_acc, perm_q[hit_idx]);
        lk_hit    = lk_valid && any_match && !denied;
        lk_fault  = lk_valid && any_match && denied;
        lk_miss   = lk_valid && !any_match;
        lk_paddr  = lk_hit ? {pfn_q[hit_idx], lk_off} : '0;
    end

    // Lowest-numbered invalid entry, scanned downwards so index 0 wins.
    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
        end
        victim_idx = have_free ? free_idx : lru_idx;
    end

    // Request arbitration: kills beat fills; any update beats a recency touch.
    always_comb begin
        if (flush_en)    kill_mask = '1;
        else if (inv_en) kill_mask = inv_match;
        else             kill_mask = '0;
        fill_go   = fill_en && !flush_en && !inv_en;
        touch_en  = fill_go
                  || (lk_valid && any_match && !fill_en && !inv_en && !flush_en);
        touch_idx = fill_go ? victim_idx : hit_idx;
    end

    xlat_sat_ctr #(.W(CNT_W)) u_hit_ctr (
        .clk(clk), .rst_n(rst_n), .inc(lk_hit), .count(hit_count)
    );

    xlat_sat_ctr #(.W(CNT_W)) u_miss_ctr (
        .clk(clk), .rst_n(rst_n), .inc(lk_miss), .count(miss_count)
    );

endmodule

// File: rtl/xlat_cache_chk.sv
// Module xlat_cache_chk
// Property checker bound to xlat_cache. It observes the ports together
// with the valid vector and the recency ages, which separate submodules
// drive.
module xlat_cache_chk #(
    parameter int N     = 8,
    parameter int VPN_W = 20,
    parameter int PFN_W = 20,
    parameter int TAG_W = 8,
    parameter int OFF_W = 12,
    parameter int CNT_W = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
    localparam int PA_W  = PFN_W + OFF_W
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    lk_valid,
    input logic [VPN_W-1:0]        lk_vpn,
    input logic [OFF_W-1:0]        lk_off,
    input logic [TAG_W-1:0]        lk_tag,
    input logic                    lk_hit,
    input logic                    lk_miss,
    input logic                    lk_fault,
    input logic [PA_W-1:0]         lk_paddr,
    input logic                    fill_en,
    input logic [VPN_W-1:0]        fill_vpn,
    input logic [TAG_W-1:0]        fill_tag,
    input logic                    inv_en,
    input logic                    flush_en,
    input logic [CNT_W-1:0]        hit_count,
    input logic [CNT_W-1:0]        miss_count,
    input logic [N-1:0]            valid_q,
    input logic [N-1:0][IDX_W-1:0] age_q
);

    logic [N-1:0] mru_vec;
    logic [N-1:0] lru_vec;

    // Flag which entries hold the youngest and the oldest age.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            mru_vec[i] = (age_q[i] == '0);
            lru_vec[i] = (age_q[i] == IDX_W'(N - 1));
        end
    end

    p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lk_hit, lk_miss, lk_fault}));

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(lk_hit || lk_miss || lk_fault));

    p_paddr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_paddr == '0));

    p_paddr_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_off));

    p_mru_unique_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(mru_vec));

    p_lru_unique_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(lru_vec));

    p_fill_found_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !inv_en && !flush_en) |=>
        (!(lk_valid && lk_vpn == $past(fill_vpn) && lk_tag == $past(fill_tag)) || !lk_miss));

    p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_en |=> (valid_q == '0));

    p_hit_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && hit_count != '1) |=> (hit_count == $past(hit_count) + 1'b1));

    p_hit_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_count == '1) |=> (hit_count == '1));

    p_miss_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_count == '1) |=> (miss_count == '1));

endmodule

bind xlat_cache xlat_cache_chk #(
    .N(N), .VPN_W(VPN_W), .PFN_W(PFN_W), .TAG_W(TAG_W), .OFF_W(OFF_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_off(lk_off),
    .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
    .lk_paddr(lk_paddr), .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_tag(fill_tag),
    .inv_en(inv_en), .flush_en(flush_en), .hit_count(hit_count),
    .miss_count(miss_count), .valid_q(valid_q), .age_q(age_q)
);

// File: tb/tb_xlat_cache.sv
// Bench for xlat_cache: directed corner cases, then seeded random traffic,
// all compared each cycle with a reference model kept in bench functions.
module tb_xlat_cache;

    localparam int N     = 8;
    localparam int VW    = 20;
    localparam int PW    = 20;
    localparam int TW    = 8;
    localparam int OW    = 12;
    localparam int CW    = 6;
    localparam int CMAX  = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid, lk_hit, lk_miss, lk_fault;
    logic [VW-1:0] lk_vpn, fill_vpn, inv_vpn;
    logic [OW-1:0] lk_off;
    logic [TW-1:0] lk_tag, fill_tag, inv_tag;
    logic [2:0] lk_acc, fill_perm;
    logic [PW+OW-1:0] lk_paddr;
    logic fill_en, inv_en, flush_en;
    logic [PW-1:0] fill_pfn;
    logic [CW-1:0] hit_count, miss_count;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    bit          m_valid [N];
    logic [VW-1:0] m_vpn [N];
    logic [TW-1:0] m_tag [N];
    logic [PW-1:0] m_pfn [N];
    logic [2:0]  m_perm [N];
    int          m_age [N];
    int          m_hits, m_misses;

    always #2.5 clk = ~clk;

    xlat_cache #(.N(N), .VPN_W(VW), .PFN_W(PW), .TAG_W(TW), .OFF_W(OW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_off(lk_off),
        .lk_tag(lk_tag), .lk_acc(lk_acc), .lk_hit(lk_hit), .lk_miss(lk_miss),
        .lk_fault(lk_fault), .lk_paddr(lk_paddr), .fill_en(fill_en), .fill_vpn(fill_vpn),
        .fill_tag(fill_tag), .fill_pfn(fill_pfn), .fill_perm(fill_perm), .inv_en(inv_en),
        .inv_vpn(inv_vpn), .inv_tag(inv_tag), .flush_en(flush_en),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    task automatic chk(string rq, string what, longint got, longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", rq, what, got, exp);
        end
    endtask

    function automatic int find_key(logic [VW-1:0] v, logic [TW-1:0] t);
        for (int i = 0; i < N; i++)
            if (m_valid[i] && m_vpn[i] == v && m_tag[i] == t) return i;
        return -1;
    endfunction

    function automatic void touch(int k);
        int a = m_age[k];
        for (int i = 0; i < N; i++) if (m_age[i] < a) m_age[i]++;
        m_age[k] = 0;
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_age[i] = i;
        end
        m_hits = 0; m_misses = 0;
    endfunction

    // Apply one clock edge of the inputs to the model.
    function automatic void model_step();
        int k = find_key(lk_vpn, lk_tag);
        bit den = (k >= 0) && ((lk_acc & ~m_perm[k]) != 0);
        if (lk_valid && k >= 0 && !den && m_hits < CMAX) m_hits++;
        if (lk_valid && k < 0 && m_misses < CMAX) m_misses++;
        if (flush_en) begin
            for (int i = 0; i < N; i++) m_valid[i] = 0;
        end else if (inv_en) begin
            int j = find_key(inv_vpn, inv_tag);
            if (j >= 0) m_valid[j] = 0;
        end else if (fill_en) begin
            int v = -1;
            for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) v = i;
            if (v < 0) for (int i = 0; i < N; i++) if (m_age[i] == N - 1) v = i;
            m_valid[v] = 1; m_vpn[v] = fill_vpn; m_tag[v] = fill_tag;
            m_pfn[v] = fill_pfn; m_perm[v] = fill_perm;
            touch(v);
        end else if (lk_valid && k >= 0) begin
            touch(k);
        end
    endfunction

    task automatic idle();
        lk_valid = 0; lk_vpn = '0; lk_off = '0; lk_tag = '0; lk_acc = '0;
        fill_en = 0; fill_vpn = '0; fill_tag = '0; fill_pfn = '0; fill_perm = '0;
        inv_en = 0; inv_vpn = '0; inv_tag = '0; flush_en = 0;
    endtask

    // Called just after a negedge with inputs set: compare, then clock.
    task automatic step(string rq);
        int k;
        bit den, eh, ef, em;
        logic [PW+OW-1:0] ep;
        #1;
        k = find_key(lk_vpn, lk_tag);
        den = (k >= 0) && ((lk_acc & ~m_perm[k]) != 0);
        eh = lk_valid && k >= 0 && !den;
        ef = lk_valid && k >= 0 && den;
        em = lk_valid && k < 0;
        ep = eh ? {m_pfn[k], lk_off} : '0;
        chk(rq, "hit", lk_hit, eh);
        chk(rq, "fault", lk_fault, ef);
        chk(rq, "miss", lk_miss, em);
        chk(rq, "paddr", lk_paddr, ep);
        chk("R9", "hit_count", hit_count, m_hits);
        chk("R9", "miss_count", miss_count, m_misses);
        @(posedge clk);
        model_step();
        @(negedge clk);
        idle();
    endtask

    task automatic look(logic [VW-1:0] v, logic [TW-1:0] t, logic [2:0] acc, string rq);
        lk_valid = 1; lk_vpn = v; lk_tag = t; lk_acc = acc; lk_off = OW'(v * 7 + 3);
        step(rq);
    endtask

    task automatic fill(logic [VW-1:0] v, logic [TW-1:0] t, logic [PW-1:0] p, logic [2:0] pm);
        fill_en = 1; fill_vpn = v; fill_tag = t; fill_pfn = p; fill_perm = pm;
        step("R5");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        idle();
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10: reset state
        chk("R10", "hit_count at reset", hit_count, 0);
        chk("R10", "miss_count at reset", miss_count, 0);
        look(20'h100, 8'd1, 3'b001, "R10");

        // R5: fill all slots in order, R1/R2 lookups
        for (int i = 0; i < N; i++) fill(20'h100 + VW'(i), 8'd1, 20'h200 + PW'(i), 3'b111);
        for (int i = 0; i < N; i++) look(20'h100 + VW'(i), 8'd1, 3'b011, "R2");
        look(20'h103, 8'd2, 3'b001, "R1");
        // R4: touch entry 0 then refill: victim follows recency ranking
        look(20'h100, 8'd1, 3'b001, "R4");
        fill(20'h180, 8'd1, 20'h280, 3'b111);
        look(20'h101, 8'd1, 3'b001, "R4");
        look(20'h100, 8'd1, 3'b001, "R4");
        look(20'h180, 8'd1, 3'b100, "R5");

        // R3: read-only page
        fill(20'h300, 8'd4, 20'h3AB, 3'b001);
        look(20'h300, 8'd4, 3'b010, "R3");
        look(20'h300, 8'd4, 3'b100, "R3");
        look(20'h300, 8'd4, 3'b001, "R3");

        // R7: wrong tag invalidate has no effect, right tag clears
        inv_en = 1; inv_vpn = 20'h300; inv_tag = 8'd9; step("R7");
        look(20'h300, 8'd4, 3'b001, "R7");
        inv_en = 1; inv_vpn = 20'h300; inv_tag = 8'd4; step("R7");
        look(20'h300, 8'd4, 3'b001, "R7");
        look(20'h180, 8'd1, 3'b001, "R7");

        // R8: invalidate beats fill
        inv_en = 1; inv_vpn = 20'h180; inv_tag = 8'd1;
        fill_en = 1; fill_vpn = 20'h555; fill_tag = 8'd3; fill_pfn = 20'h777; fill_perm = 3'b111;
        step("R8");
        look(20'h555, 8'd3, 3'b001, "R8");
        // R6/R8: flush beats fill, all entries gone
        flush_en = 1;
        fill_en = 1; fill_vpn = 20'h556; fill_tag = 8'd3; fill_pfn = 20'h778; fill_perm = 3'b111;
        step("R6");
        look(20'h556, 8'd3, 3'b001, "R8");
        look(20'h100, 8'd1, 3'b001, "R6");
        look(20'h102, 8'd1, 3'b001, "R6");

        // R9: saturate both counters
        fill(20'h042, 8'd0, 20'h0FF, 3'b111);
        for (int i = 0; i < 70; i++) look(20'h042, 8'd0, 3'b001, "R9");
        for (int i = 0; i < 70; i++) look(20'h043, 8'd0, 3'b001, "R9");

        // Random mix: R1 R3 R4 R5 R7 R8 under a small key space
        rst_n = 0; @(negedge clk); rst_n = 1; model_reset();
        for (int c = 0; c < 4000; c++) begin
            logic [VW-1:0] fv;
            logic [TW-1:0] ft;
            lk_valid = ($urandom % 10) < 7;
            lk_vpn = VW'($urandom % 12); lk_tag = TW'($urandom % 2);
            lk_acc = 3'($urandom % 8); lk_off = OW'($urandom);
            fv = VW'($urandom % 12); ft = TW'($urandom % 2);
            if (($urandom % 4) == 0 && find_key(fv, ft) < 0) begin
                fill_en = 1; fill_vpn = fv; fill_tag = ft;
                fill_pfn = PW'($urandom); fill_perm = 3'($urandom % 8);
            end
            if (($urandom % 20) == 0) begin
                inv_en = 1; inv_vpn = VW'($urandom % 12); inv_tag = TW'($urandom % 2);
            end
            flush_en = ($urandom % 60) == 0;
            step("R4 R5 R1 R3 R7 R8 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule